// File: doc/BRIEF.md
# Serial line unit register and control block

This block is the bus-facing side of an asynchronous serial line unit. It has four 16-bit word registers on a simple word bus: receiver status, receiver data, transmitter status and transmitter data. A 2-bit index selects the register, and single-cycle read and write strobes access it. Characters come in from a byte-level receiver together with framing and parity flags. Characters go out to a byte-level transmitter: the block sends a one-cycle start pulse, and the transmitter returns a done pulse once the character time has passed.

The block keeps the receiver and transmitter done/ready flags, detects overrun, and optionally drives a line break. It has a maintenance loopback that sends every transmitted byte back into its own receiver. It raises two interrupt requests, one for receive and one for transmit. Each request stays pending until the bus grant acknowledges it. A vector output gives the base vector for receive and base+4 for transmit, with receive taking priority.

Read data is combinational from the register state. A write or an access side effect takes effect at the clock edge that samples the strobe. `init_i` is the synchronous bus initialise. It clears the same state as the asynchronous reset.

Top module: `serial_line_regs`

## Requirements
- R1: Register index 0 (receiver status) reads bit 11 = receiver active, bit 7 = receiver done and bit 6 = receive interrupt enable. All other bits read 0, including the reader-enable bit 0. A write stores bit 6 as the interrupt enable and bit 0 as the hidden reader enable.
- R2: A write to index 0 that changes the stored reader enable from 0 to 1 clears receiver done. A write that keeps it at 1 leaves done unchanged.
- R3: Any read or write strobe to index 1 (receiver data) clears receiver done. A write to index 1 does not change the stored character or error flags.
- R4: Index 1 reads the character in bits 7..0. When `err_rep_en_i` is 1, it also reads overrun at bit 14, framing at bit 13, parity at bit 12, and bit 15 set when any of those three is set. When `err_rep_en_i` is 0, bits 15..8 read 0.
- R5: On a character arrival, all three error flags are replaced: overrun takes the value of done before the arrival, and framing and parity come from the receiver. Done is set and active is cleared. An arrival wins over a clear of done in the same cycle.
- R6: The receive request `irq_rx_o` becomes pending at the clock edge where (done AND receive interrupt enable) goes from 0 to 1. This can happen on an arrival or on a status write. The request stays pending until `ack_rx_i`.
- R7: A write to index 3 (transmitter data) latches bits 7..0 onto `tx_byte_o` and clears ready. It pulses `tx_start_o` for the one following cycle. `tx_done_i` sets ready again. A write in the same cycle wins over `tx_done_i`. Index 3 reads 0.
- R8: The transmit request `irq_tx_o` becomes pending on the 0-to-1 edge of (ready AND transmit interrupt enable). This can happen on `tx_done_i` or on a status write. The request stays pending until `ack_tx_i`.
- R9: Index 2 (transmitter status) reads bit 7 = ready, bit 6 = interrupt enable, bit 2 = maintenance and bit 0 = break. A write stores bits 6, 2 and 0.
- R10: `line_break_o` is high exactly while the break bit is set and the `brk_strap_i` strap is high.
- R11: A transmit started while maintenance is set sets receiver active. When that transmission reports done, the byte is delivered to the receiver with no framing or parity error. A line character arriving in that same cycle is dropped.
- R12: Reset or `init_i` clears all receiver state, the transmit interrupt enable, maintenance and break, the transmit byte and both pending requests, and sets ready to 1.
- R13: `irq_vec_o` equals VEC_BASE while the receive request is pending or none is pending. It equals VEC_BASE+4 when only the transmit request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous bus initialise |
| reg_idx_i | input | 2 | Register index |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| err_rep_en_i | input | 1 | Error reporting strap |
| brk_strap_i | input | 1 | Break enable strap |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 8 | Received character |
| rx_frame_err_i | input | 1 | Framing error of the character |
| rx_parity_err_i | input | 1 | Parity error of the character |
| tx_start_o | output | 1 | Transmit start pulse |
| tx_byte_o | output | 8 | Byte to transmit |
| tx_done_i | input | 1 | Transmission complete |
| line_break_o | output | 1 | Line break drive |
| irq_rx_o | output | 1 | Receive interrupt pending |
| irq_tx_o | output | 1 | Transmit interrupt pending |
| ack_rx_i | input | 1 | Receive grant acknowledge |
| ack_tx_i | input | 1 | Transmit grant acknowledge |
| irq_vec_o | output | 9 | Vector of the serviced request |

## Verification
On every cycle, the assertions check the following:
- An arrival sets done, and overrun follows a still-set done.
- A receiver data access clears done unless a character arrives in the same cycle.
- A transmitter data write drops ready and starts a transmit, and done restores ready.
- A maintenance start raises receiver active.
- Pending requests hold until acknowledged and are cleared by initialise.

Only the bench scenarios can show the edge-only nature of the interrupts. They also show the hidden reader-enable edge, the error bit layout under both strap settings, and the loopback byte landing in the receiver data register. Finally, they show receive-over-transmit vector priority, all compared against a cycle-by-cycle reference model.

// File: rtl/slu_pkg.sv
package slu_pkg;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    IDX_RX_STAT = 2'd0,
    IDX_RX_DATA = 2'd1,
    IDX_TX_STAT = 2'd2,
    IDX_TX_DATA = 2'd3
  } reg_idx_e;

  // receiver status
  localparam int RS_ACT = 11;
  localparam int RS_DONE = 7;
  localparam int RS_IE = 6;
  localparam int RS_RDE = 0;
  // receiver data
  localparam int RD_ERR = 15;
  localparam int RD_OVR = 14;
  localparam int RD_FRM = 13;
  localparam int RD_PAR = 12;
  // transmitter status
  localparam int TS_RDY = 7;
  localparam int TS_IE = 6;
  localparam int TS_MNT = 2;
  localparam int TS_BRK = 0;
endpackage

// File: rtl/slu_rx_ctrl.sv
module slu_rx_ctrl #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              stat_wr_i,
  input  logic              ie_wd_i,
  input  logic              rde_wd_i,
  input  logic              buf_acc_i,
  input  logic              chr_vld_i,
  input  logic [CHAR_W-1:0] chr_i,
  input  logic              fe_i,
  input  logic              pe_i,
  input  logic              start_i,
  output logic              active_o,
  output logic              done_o,
  output logic              ie_o,
  output logic [CHAR_W-1:0] chr_o,
  output logic              ovr_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              rise_o
);
  logic act_q, act_d, done_q, done_d, ie_q, ie_d, rde_q, rde_d;
  logic ovr_q, ovr_d, fe_q, fe_d, pe_q, pe_d;
  logic [CHAR_W-1:0] chr_q, chr_d;

  always_comb begin
    act_d  = act_q;
    done_d = done_q;
    ie_d   = ie_q;
    rde_d  = rde_q;
    chr_d  = chr_q;
    ovr_d  = ovr_q;
    fe_d   = fe_q;
    pe_d   = pe_q;
    if (stat_wr_i) begin
      ie_d  = ie_wd_i;
      rde_d = rde_wd_i;
      if (!rde_q && rde_wd_i) done_d = 1'b0;
    end
    if (buf_acc_i) done_d = 1'b0;
    if (chr_vld_i) begin
      ovr_d  = done_q;
      fe_d   = fe_i;
      pe_d   = pe_i;
      chr_d  = chr_i;
      done_d = 1'b1;
      act_d  = 1'b0;
    end
    if (start_i) act_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; done_q <= 1'b0; ie_q <= 1'b0; rde_q <= 1'b0;
      ovr_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0; chr_q <= '0;
    end else if (init_i) begin
      act_q <= 1'b0; done_q <= 1'b0; ie_q <= 1'b0; rde_q <= 1'b0;
      ovr_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0; chr_q <= '0;
    end else begin
      act_q <= act_d; done_q <= done_d; ie_q <= ie_d; rde_q <= rde_d;
      ovr_q <= ovr_d; fe_q <= fe_d; pe_q <= pe_d; chr_q <= chr_d;
    end
  end

  assign rise_o   = !init_i && !(done_q && ie_q) && done_d && ie_d;
  assign active_o = act_q;
  assign done_o   = done_q;
  assign ie_o     = ie_q;
  assign chr_o    = chr_q;
  assign ovr_o    = ovr_q;
  assign fe_o     = fe_q;
  assign pe_o     = pe_q;

  // R5
  arrive_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_vld_i && !init_i |=> done_o);
  // R5
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_vld_i && done_o && !init_i |=> ovr_o);
  // R3
  buf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_acc_i && !chr_vld_i && !init_i |=> !done_o);
  // R12
  rx_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !done_o && !active_o && !ie_o);
endmodule

// File: rtl/slu_tx_ctrl.sv
module slu_tx_ctrl #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              stat_wr_i,
  input  logic              ie_wd_i,
  input  logic              mnt_wd_i,
  input  logic              brk_wd_i,
  input  logic              buf_wr_i,
  input  logic [CHAR_W-1:0] byte_wd_i,
  input  logic              done_i,
  output logic              ready_o,
  output logic              ie_o,
  output logic              mnt_o,
  output logic              brk_o,
  output logic              start_o,
  output logic [CHAR_W-1:0] byte_o,
  output logic              lb_start_o,
  output logic              lb_vld_o,
  output logic              rise_o
);
  logic rdy_q, rdy_d, ie_q, ie_d, mnt_q, mnt_d, brk_q, brk_d;
  logic lb_q, lb_d, start_q;
  logic [CHAR_W-1:0] byte_q, byte_d;

  always_comb begin
    rdy_d  = rdy_q;
    ie_d   = ie_q;
    mnt_d  = mnt_q;
    brk_d  = brk_q;
    lb_d   = lb_q;
    byte_d = byte_q;
    if (stat_wr_i) begin
      ie_d  = ie_wd_i;
      mnt_d = mnt_wd_i;
      brk_d = brk_wd_i;
    end
    if (done_i) begin
      rdy_d = 1'b1;
      lb_d  = 1'b0;
    end
    if (buf_wr_i) begin
      byte_d = byte_wd_i;
      rdy_d  = 1'b0;
      lb_d   = mnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b1; ie_q <= 1'b0; mnt_q <= 1'b0; brk_q <= 1'b0;
      lb_q <= 1'b0; byte_q <= '0; start_q <= 1'b0;
    end else if (init_i) begin
      rdy_q <= 1'b1; ie_q <= 1'b0; mnt_q <= 1'b0; brk_q <= 1'b0;
      lb_q <= 1'b0; byte_q <= '0; start_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d; ie_q <= ie_d; mnt_q <= mnt_d; brk_q <= brk_d;
      lb_q <= lb_d; byte_q <= byte_d; start_q <= buf_wr_i;
    end
  end

  assign rise_o     = !init_i && !(rdy_q && ie_q) && rdy_d && ie_d;
  assign ready_o    = rdy_q;
  assign ie_o       = ie_q;
  assign mnt_o      = mnt_q;
  assign brk_o      = brk_q;
  assign start_o    = start_q;
  assign byte_o     = byte_q;
  assign lb_start_o = buf_wr_i && mnt_q;
  assign lb_vld_o   = done_i && lb_q;

  // R7
  wr_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_i && !init_i |=> !ready_o && start_o);
  // R7
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !buf_wr_i && !init_i |=> ready_o);
  // R12
  tx_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> ready_o && !mnt_o && !brk_o && !ie_o);
endmodule

// File: rtl/slu_irq_pend.sv
module slu_irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic rise_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (init_i)  pend_q <= 1'b0;
    else if (rise_i)  pend_q <= 1'b1;
    else if (ack_i)   pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !ack_i && !init_i |=> pend_o);
  // R12
  init_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !pend_o);
endmodule

// File: rtl/serial_line_regs.sv
module serial_line_regs
  import slu_pkg::*;
#(
  parameter int VEC_W    = 9,
  parameter int VEC_BASE = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [1:0]        reg_idx_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              err_rep_en_i,
  input  logic              brk_strap_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_char_i,
  input  logic              rx_frame_err_i,
  input  logic              rx_parity_err_i,
  output logic              tx_start_o,
  output logic [CHAR_W-1:0] tx_byte_o,
  input  logic              tx_done_i,
  output logic              line_break_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o,
  input  logic              ack_rx_i,
  input  logic              ack_tx_i,
  output logic [VEC_W-1:0]  irq_vec_o
);
  localparam int NCH = 2;
  localparam logic [VEC_W-1:0] VEC_RX = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] VEC_TX = VEC_W'(VEC_BASE + 4);

  reg_idx_e idx;
  assign idx = reg_idx_e'(reg_idx_i);

  logic rs_wr, rd_acc, ts_wr, td_wr;
  assign rs_wr  = wr_i && idx == IDX_RX_STAT;
  assign rd_acc = (rd_i || wr_i) && idx == IDX_RX_DATA;
  assign ts_wr  = wr_i && idx == IDX_TX_STAT;
  assign td_wr  = wr_i && idx == IDX_TX_DATA;

  logic rx_act, rx_done, rx_ie, rx_ovr, rx_fe, rx_pe;
  logic [CHAR_W-1:0] rx_chr;
  logic tx_rdy, tx_ie, tx_mnt, tx_brk, lb_start, lb_vld;
  logic [NCH-1:0] rise, ack, pend;

  // loopback byte takes precedence over the line
  logic              arr_vld, arr_fe, arr_pe;
  logic [CHAR_W-1:0] arr_chr;
  assign arr_vld = lb_vld || rx_valid_i;
  assign arr_chr = lb_vld ? tx_byte_o : rx_char_i;
  assign arr_fe  = lb_vld ? 1'b0 : rx_frame_err_i;
  assign arr_pe  = lb_vld ? 1'b0 : rx_parity_err_i;

  slu_rx_ctrl #(.CHAR_W(CHAR_W)) u_rx (
    .clk_i, .rst_ni, .init_i,
    .stat_wr_i (rs_wr),
    .ie_wd_i   (wdata_i[RS_IE]),
    .rde_wd_i  (wdata_i[RS_RDE]),
    .buf_acc_i (rd_acc),
    .chr_vld_i (arr_vld),
    .chr_i     (arr_chr),
    .fe_i      (arr_fe),
    .pe_i      (arr_pe),
    .start_i   (lb_start),
    .active_o  (rx_act),
    .done_o    (rx_done),
    .ie_o      (rx_ie),
    .chr_o     (rx_chr),
    .ovr_o     (rx_ovr),
    .fe_o      (rx_fe),
    .pe_o      (rx_pe),
    .rise_o    (rise[0])
  );

  slu_tx_ctrl #(.CHAR_W(CHAR_W)) u_tx (
    .clk_i, .rst_ni, .init_i,
    .stat_wr_i  (ts_wr),
    .ie_wd_i    (wdata_i[TS_IE]),
    .mnt_wd_i   (wdata_i[TS_MNT]),
    .brk_wd_i   (wdata_i[TS_BRK]),
    .buf_wr_i   (td_wr),
    .byte_wd_i  (wdata_i[CHAR_W-1:0]),
    .done_i     (tx_done_i),
    .ready_o    (tx_rdy),
    .ie_o       (tx_ie),
    .mnt_o      (tx_mnt),
    .brk_o      (tx_brk),
    .start_o    (tx_start_o),
    .byte_o     (tx_byte_o),
    .lb_start_o (lb_start),
    .lb_vld_o   (lb_vld),
    .rise_o     (rise[1])
  );

  assign ack = {ack_tx_i, ack_rx_i};

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    slu_irq_pend u_pend (
      .clk_i, .rst_ni, .init_i,
      .rise_i (rise[c]),
      .ack_i  (ack[c]),
      .pend_o (pend[c])
    );
  end

  assign irq_rx_o  = pend[0];
  assign irq_tx_o  = pend[1];
  assign irq_vec_o = (!pend[0] && pend[1]) ? VEC_TX : VEC_RX;
  assign line_break_o = tx_brk && brk_strap_i;

  logic any_err;
  assign any_err = rx_ovr || rx_fe || rx_pe;

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      IDX_RX_STAT: begin
        rdata_o[RS_ACT]  = rx_act;
        rdata_o[RS_DONE] = rx_done;
        rdata_o[RS_IE]   = rx_ie;
      end
      IDX_RX_DATA: begin
        rdata_o[CHAR_W-1:0] = rx_chr;
        if (err_rep_en_i) begin
          rdata_o[RD_ERR] = any_err;
          rdata_o[RD_OVR] = rx_ovr;
          rdata_o[RD_FRM] = rx_fe;
          rdata_o[RD_PAR] = rx_pe;
        end
      end
      IDX_TX_STAT: begin
        rdata_o[TS_RDY] = tx_rdy;
        rdata_o[TS_IE]  = tx_ie;
        rdata_o[TS_MNT] = tx_mnt;
        rdata_o[TS_BRK] = tx_brk;
      end
      default: rdata_o = '0;
    endcase
  end

  // R11
  lb_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    td_wr && tx_mnt && !init_i |=> rx_act);
  // R11
  lb_deliver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_vld && !init_i |=> rx_done && !rx_fe && !rx_pe);
endmodule

// File: tb/test_serial_line_regs.sv
module test_serial_line_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic init = 0, rd = 0, wr = 0, errs = 1, brks = 1;
  logic rxv = 0, fe = 0, pe = 0, txd = 0, ackr = 0, ackt = 0;
  logic [1:0] idx = 0;
  logic [15:0] wd = 0;
  logic [7:0] rxc = 0;
  logic [15:0] rdata;
  logic tx_start, lbrk, irq_rx, irq_tx;
  logic [7:0] tx_byte;
  logic [8:0] vec;

  serial_line_regs i_serial_line_regs (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .reg_idx_i(idx),
    .rd_i(rd), .wr_i(wr), .wdata_i(wd), .rdata_o(rdata),
    .err_rep_en_i(errs), .brk_strap_i(brks), .rx_valid_i(rxv),
    .rx_char_i(rxc), .rx_frame_err_i(fe), .rx_parity_err_i(pe),
    .tx_start_o(tx_start), .tx_byte_o(tx_byte), .tx_done_i(txd),
    .line_break_o(lbrk), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx),
    .ack_rx_i(ackr), .ack_tx_i(ackt), .irq_vec_o(vec)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R12";

  // reference model state
  bit m_act, m_done, m_rie, m_rde, m_or, m_fe, m_pe;
  bit m_rdy = 1, m_tie, m_mnt, m_brk, m_loop, m_txv, m_prx, m_ptx;
  int m_ch, m_xb;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(int i);
    int v;
    v = 0;
    case (i)
      0: v = (m_act << 11) | (m_done << 7) | (m_rie << 6);
      1: begin
        v = m_ch;
        if (errs) v |= (((m_or | m_fe | m_pe) ? 1 : 0) << 15) | (m_or << 14) | (m_fe << 13) | (m_pe << 12);
      end
      2: v = (m_rdy << 7) | (m_tie << 6) | (m_mnt << 2) | m_brk;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic model_reset();
    m_act = 0; m_done = 0; m_rie = 0; m_rde = 0; m_or = 0; m_fe = 0; m_pe = 0;
    m_ch = 0; m_rdy = 1; m_tie = 0; m_mnt = 0; m_brk = 0; m_loop = 0;
    m_txv = 0; m_prx = 0; m_ptx = 0; m_xb = 0;
  endtask

  task automatic model_step();
    bit lb, arr, o_done, o_rde, o_mnt, rc_old, tc_old;
    int ach;
    bit afe, ape;
    if (init) begin model_reset(); return; end
    o_done = m_done; o_rde = m_rde; o_mnt = m_mnt;
    rc_old = m_done && m_rie; tc_old = m_rdy && m_tie;
    lb = txd && m_loop;
    arr = lb || rxv;
    ach = lb ? m_xb : rxc;
    afe = lb ? 0 : fe;
    ape = lb ? 0 : pe;
    if (wr && idx == 0) begin
      m_rie = wd[6]; m_rde = wd[0];
      if (!o_rde && wd[0]) m_done = 0;
    end
    if ((rd || wr) && idx == 1) m_done = 0;
    if (arr) begin
      m_or = o_done; m_fe = afe; m_pe = ape; m_ch = ach; m_done = 1; m_act = 0;
    end
    if (wr && idx == 3 && o_mnt) m_act = 1;
    if (wr && idx == 2) begin m_tie = wd[6]; m_mnt = wd[2]; m_brk = wd[0]; end
    if (txd) begin m_rdy = 1; m_loop = 0; end
    m_txv = wr && idx == 3;
    if (m_txv) begin m_xb = wd[7:0]; m_rdy = 0; m_loop = o_mnt; end
    if (!rc_old && m_done && m_rie) m_prx = 1;
    else if (ackr) m_prx = 0;
    if (!tc_old && m_rdy && m_tie) m_ptx = 1;
    else if (ackt) m_ptx = 0;
  endtask

  // inputs are already driven (just after a negedge)
  task automatic tick();
    #2;
    chk({cur_req, " read data"}, rdata, exp_rd(idx));
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R6 irq_rx", irq_rx, m_prx);
    chk("R8 irq_tx", irq_tx, m_ptx);
    chk("R7 tx_start", tx_start, m_txv);
    chk("R7 tx_byte", tx_byte, m_xb);
    chk("R10 line_break", lbrk, m_brk && brks);
    chk("R13 vector", vec, (!m_prx && m_ptx) ? 52 : 48);
    init = 0; rd = 0; wr = 0; rxv = 0; fe = 0; pe = 0; txd = 0;
    ackr = 0; ackt = 0;
  endtask

  task automatic wreg(int i, int d); idx = 2'(i); wr = 1; wd = 16'(d); tick(); endtask
  task automatic rreg(int i); idx = 2'(i); rd = 1; tick(); endtask
  task automatic rx_char(int c, bit f, bit p); rxv = 1; rxc = 8'(c); fe = f; pe = p; tick(); endtask
  task automatic idle(int n, int i); for (int k = 0; k < n; k++) begin idx = 2'(i); tick(); end endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    cur_req = "R12"; for (int i = 0; i < 4; i++) idle(1, i);
    // R1 status write/readback, hidden reader enable
    cur_req = "R1"; wreg(0, 16'hFFFF); idle(1, 0); wreg(0, 16'h0040); idle(1, 0);
    // R6 arrival with enable -> request; R4 data read; R3 clear
    cur_req = "R4"; rx_char(8'h41, 0, 0); idle(1, 1); rreg(1);
    cur_req = "R3"; idle(1, 0); ackr = 1; idle(1, 0);
    // R5 overrun with error flags, both strap settings
    cur_req = "R5"; rx_char(8'h11, 0, 0); rx_char(8'h22, 1, 1); idle(1, 1);
    cur_req = "R4"; errs = 0; idle(1, 1); errs = 1; idle(1, 1);
    // R5 arrival beats same-cycle read
    cur_req = "R5"; idx = 1; rd = 1; rxv = 1; rxc = 8'h33; tick(); idle(1, 0); idle(1, 1);
    ackr = 1; idle(1, 0);
    // R2 reader enable edge
    cur_req = "R2"; wreg(0, 16'h0000); rx_char(8'h44, 0, 0); wreg(0, 16'h0001); idle(1, 0);
    rx_char(8'h45, 0, 0); wreg(0, 16'h0001); idle(1, 0);
    // R6 enable write while done set -> request
    cur_req = "R6"; wreg(0, 16'h0041); idle(1, 0); ackr = 1; idle(1, 0);
    // R3 write to data register clears done, keeps char
    cur_req = "R3"; wreg(1, 16'hFFFF); idle(1, 0); idle(1, 1);
    // R8 enable while ready -> request, R7 transmit
    cur_req = "R9"; wreg(2, 16'h0040); idle(1, 2); ackt = 1; idle(1, 2);
    cur_req = "R7"; wreg(3, 16'h01A5); idle(3, 2); idle(1, 3);
    txd = 1; tick(); idle(1, 2); ackt = 1; idle(1, 2);
    // R7 write beats done in same cycle
    wreg(3, 16'h0011); idx = 3; wr = 1; wd = 16'h0022; txd = 1; tick(); idle(1, 2);
    txd = 1; tick(); ackt = 1; idle(1, 2);
    // R10 break with strap on/off
    cur_req = "R10"; wreg(2, 16'h0041); brks = 0; idle(1, 2); brks = 1; idle(1, 2);
    wreg(2, 16'h0040); idle(1, 2);
    // R11 maintenance loopback; line char in delivery cycle dropped
    cur_req = "R11"; rreg(1); wreg(0, 16'h0040); wreg(2, 16'h0044); wreg(3, 16'h005C);
    idle(2, 0); txd = 1; rxv = 1; rxc = 8'h99; fe = 1; tick(); idle(1, 0); idle(1, 1);
    // R13 both pending -> receive vector, then transmit vector
    cur_req = "R13"; idle(1, 2); ackr = 1; idle(1, 2); ackt = 1; idle(1, 2);
    // R12 init mid-operation
    cur_req = "R12"; wreg(2, 16'h0045); wreg(3, 16'h0077); rx_char(8'h55, 1, 0);
    init = 1; tick(); for (int i = 0; i < 4; i++) idle(1, i);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule